// File: doc/BRIEF.md
# Branch Direction Predictor with Fetch Gate

This block predicts the direction of conditional branches as they are fetched, and it decides whether the fetch unit may fetch in the next cycle. The fetch unit presents the address of the fetched instruction and a flag from an ideal target buffer that marks it as a conditional branch. Because the pipeline replays a committed-path trace, the real outcome of that branch is also available at fetch. The block compares its prediction with that outcome. If they differ, it closes the fetch gate.

Two prediction schemes are available, and a static mode input picks between them. In the first, every branch is predicted taken. In the second, a table of 2-bit saturating counters is indexed by the low address bits XORed with a global history of recent outcomes. After a wrong prediction, the gate stays closed until the memory stage reports that the mispredicted branch has arrived there. Fetch opens again in the cycle after that report.

Top module: `branch_dir_gate`

## Requirements
- R1: A prediction is issued only in a cycle where `fetch_en`, `fetch_valid` and `fetch_is_cbr` are all 1. In every other cycle `pred_taken` is 0, and the counter table and the history are left unchanged.
- R2: When `mode_gshare` is 0, every issued prediction is taken (`pred_taken` = 1).
- R3: When `mode_gshare` is 1, the table index is `fetch_pc[11:0]` XOR the 12-bit history. The prediction is taken when the indexed counter is 2 or 3, which means its bit 1 is set.
- R4: After reset, all 4096 counters hold 2'b10 (weakly taken), the history is zero, and `fetch_en` is 1. This also holds while reset is asserted.
- R5: Each issued prediction updates the counter at the index that produced it. The counter goes up by one on a taken outcome and down by one on a not-taken outcome, saturating at 0 and 3. This happens in either mode.
- R6: Each issued prediction shifts the history left by one bit and places the actual outcome (taken = 1) in bit 0.
- R7: If an issued prediction differs from `fetch_taken`, `fetch_en` is 0 in the next cycle. If the prediction is correct, `fetch_en` stays 1.
- R8: Once `fetch_en` is 0, it stays 0 until a cycle in which `resolve_mem` is 1. It returns to 1 in the cycle after that one.
- R9: A `resolve_mem` pulse while `fetch_en` is 1 has no effect. Branches offered while `fetch_en` is 0 neither predict nor update any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_gshare | input | 1 | 0: always taken, 1: history-hashed counters |
| fetch_valid | input | 1 | An instruction is presented at fetch |
| fetch_pc | input | 32 | Address of the fetched instruction |
| fetch_is_cbr | input | 1 | Fetched instruction is a conditional branch |
| fetch_taken | input | 1 | Actual outcome of the fetched branch |
| resolve_mem | input | 1 | The mispredicted branch is in the memory stage |
| pred_taken | output | 1 | Predicted direction for the current fetch |
| fetch_en | output | 1 | Fetch allowed in this cycle |

## Verification
The first corner case is a stray resolve pulse while fetch is open. A design that reacts to it would flip or latch the gate wrongly. The second is a branch offered while fetch is closed. A design that still looks it up would shift the history and change a counter, and later gshare predictions would then diverge. A long run of taken branches at one address fills the history with ones and drives a single counter to 3, followed by a not-taken branch. A design without saturation would wrap that counter to 0 and mispredict the following branches. The bench also checks that the gate reopens exactly one cycle after the resolve, not in the same cycle and not two cycles later.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_INIT = 2'b10;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  function automatic logic [CTR_W-1:0] ctr_next(input logic [CTR_W-1:0] cur,
                                                input logic taken);
    logic [CTR_W-1:0] res;
    res = cur;
    if (taken && cur != CTR_MAX) res = cur + 1'b1;
    else if (!taken && cur != '0) res = cur - 1'b1;
    return res;
  endfunction
endpackage

// File: rtl/bpg_pattern_table.sv
module bpg_pattern_table
  import bpg_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             dir_taken,
  input  logic             upd_en,
  input  logic             upd_taken
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] ctr_rd;
  logic [CTR_W-1:0] ctr_wr;

  always_comb begin
    ctr_rd    = ctr_q[idx];
    dir_taken = ctr_rd[CTR_W-1];
    ctr_wr    = ctr_next(ctr_rd, upd_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (upd_en) begin
      ctr_q[idx] <= ctr_wr;
    end
  end
endmodule

// File: rtl/bpg_history.sv
module bpg_history #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      always_comb hist_d = shift_en ? outcome : hist_q;
    end else begin : g_many
      always_comb hist_d = shift_en ? {hist_q[HIST_W-2:0], outcome} : hist_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/bpg_fetch_gate.sv
module bpg_fetch_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mispredict,
  input  logic resolve,
  output logic open
);
  logic blocked_q;
  logic blocked_d;

  always_comb begin
    if (blocked_q) blocked_d = !resolve;
    else           blocked_d = mispredict;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked_q <= 1'b0;
    else        blocked_q <= blocked_d;
  end

  assign open = !blocked_q;
endmodule

// File: rtl/branch_dir_gate.sv
module branch_dir_gate #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_gshare,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_is_cbr,
  input  logic            fetch_taken,
  input  logic            resolve_mem,
  output logic            pred_taken,
  output logic            fetch_en
);
  logic              lookup;
  logic              dir;
  logic              tbl_dir;
  logic              miss;
  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] idx;

  assign lookup = fetch_en & fetch_valid & fetch_is_cbr;
  assign idx    = fetch_pc[HIST_W-1:0] ^ hist;
  assign dir    = mode_gshare ? tbl_dir : 1'b1;
  assign miss   = lookup & (dir != fetch_taken);
  assign pred_taken = lookup & dir;

  bpg_pattern_table #(.IDX_W(HIST_W)) u_pht (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx),
    .dir_taken (tbl_dir),
    .upd_en    (lookup),
    .upd_taken (fetch_taken)
  );

  bpg_history #(.HIST_W(HIST_W)) u_ghr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (lookup),
    .outcome  (fetch_taken),
    .hist     (hist)
  );

  bpg_fetch_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .mispredict (miss),
    .resolve    (resolve_mem),
    .open       (fetch_en)
  );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_gshare,
  input logic fetch_valid,
  input logic fetch_is_cbr,
  input logic fetch_taken,
  input logic resolve_mem,
  input logic pred_taken,
  input logic fetch_en
);
  logic issue;
  assign issue = fetch_en && fetch_valid && fetch_is_cbr;

  a_r1_no_pred_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> !pred_taken);

  a_r2_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !mode_gshare) |-> pred_taken);

  a_r4_open_in_reset: assert property (@(posedge clk) !rst_n |-> fetch_en);

  a_r7_close_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && pred_taken != fetch_taken) |=> !fetch_en);

  a_r7_stay_open_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !(issue && pred_taken != fetch_taken)) |=> fetch_en);

  a_r8_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !resolve_mem) |=> !fetch_en);

  a_r8_reopen_after_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && resolve_mem) |=> fetch_en);
endmodule

bind branch_dir_gate bpg_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_gshare  (mode_gshare),
  .fetch_valid  (fetch_valid),
  .fetch_is_cbr (fetch_is_cbr),
  .fetch_taken  (fetch_taken),
  .resolve_mem  (resolve_mem),
  .pred_taken   (pred_taken),
  .fetch_en     (fetch_en)
);

// File: tb/sim_branch_dir_gate.sv
`timescale 1ns/1ps
module sim_branch_dir_gate;
  logic        clk;
  logic        rst_n;
  logic        mode_gshare;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic        fetch_is_cbr;
  logic        fetch_taken;
  logic        resolve_mem;
  logic        pred_taken;
  logic        fetch_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [1:0]  m_pht [4096];
  logic [11:0] m_ghr;
  bit          m_blocked;

  branch_dir_gate u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_gshare  (mode_gshare),
    .fetch_valid  (fetch_valid),
    .fetch_pc     (fetch_pc),
    .fetch_is_cbr (fetch_is_cbr),
    .fetch_taken  (fetch_taken),
    .resolve_mem  (resolve_mem),
    .pred_taken   (pred_taken),
    .fetch_en     (fetch_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] sat_upd(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) m_pht[i] = 2'b10;
    m_ghr = '0;
    m_blocked = 0;
  endtask

  task automatic step(input logic m, input logic v, input logic c, input logic t,
                      input logic r, input logic [31:0] pc, input string tag);
    logic exp_fen, lk, dir, exp_pred;
    logic [11:0] idx;
    string tf, tp;
    @(negedge clk);
    mode_gshare = m; fetch_valid = v; fetch_is_cbr = c;
    fetch_taken = t; resolve_mem = r; fetch_pc = pc;
    #1;
    exp_fen = !m_blocked;
    lk = exp_fen && v && c;
    idx = pc[11:0] ^ m_ghr;
    dir = m ? m_pht[idx][1] : 1'b1;
    exp_pred = lk && dir;
    tf = (tag != "") ? tag : (m_blocked ? "R8" : "R7");
    tp = (tag != "") ? tag : (!lk ? "R1" : (m ? "R3/R5/R6" : "R2"));
    chk(fetch_en === exp_fen, tf, fetch_en, exp_fen);
    chk(pred_taken === exp_pred, tp, pred_taken, exp_pred);
    if (lk) begin
      m_pht[idx] = sat_upd(m_pht[idx], t);
      m_ghr = {m_ghr[10:0], t};
    end
    if (m_blocked) m_blocked = !r;
    else           m_blocked = lk && (dir != t);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; mode_gshare = 1; fetch_valid = 0; fetch_pc = '0;
    fetch_is_cbr = 0; fetch_taken = 0; resolve_mem = 0;
    model_reset();
    #12;
    chk(fetch_en === 1'b1, "R4", fetch_en, 1'b1);
    chk(pred_taken === 1'b0, "R1", pred_taken, 1'b0);
    @(negedge clk); rst_n = 1;

    // R4: fresh counters predict taken at index 0
    step(1, 1, 1, 1, 0, 32'h0000_1000, "R4");
    // R3 miss closes fetch (R7)
    step(1, 1, 1, 0, 0, 32'h0000_2004, "");
    // R9: branch while closed, no prediction; R8 hold
    step(1, 1, 1, 0, 0, 32'h0000_0008, "R9");
    step(1, 1, 1, 1, 0, 32'h0000_000C, "R9");
    // R8: resolve, reopen next cycle
    step(1, 0, 0, 0, 1, 32'h0, "R8");
    step(1, 0, 0, 0, 0, 32'h0, "R8");
    // R9: stray resolve while open
    step(1, 1, 0, 0, 1, 32'h0000_0010, "R9");
    step(1, 1, 0, 0, 0, 32'h0000_0014, "R9");
    // R2: always-taken mode mispredicts a not-taken branch
    step(0, 1, 1, 0, 0, 32'h0000_0020, "R2");
    step(0, 1, 0, 0, 1, 32'h0, "R8");
    // R5: saturate one counter with taken runs, then a not-taken
    for (int k = 0; k < 20; k++) step(1, 1, 1, 1, 0, 32'h0000_0ABC, "R5");
    step(1, 1, 1, 0, 0, 32'h0000_0ABC, "R5");
    step(1, 1, 1, 1, 1, 32'h0000_0ABC, "R8");
    step(1, 1, 1, 1, 0, 32'h0000_0ABC, "R5");

    for (int k = 0; k < 4000; k++) begin
      logic [31:0] pc;
      logic rr;
      pc = ($urandom % 4 == 0) ? $urandom : (($urandom % 16) << 2);
      rr = m_blocked ? ($urandom % 3 == 0) : ($urandom % 8 == 0);
      step(k >= 300, ($urandom % 8) != 0, $urandom % 2, ($urandom % 4) != 0, rr, pc, "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule